// File: doc/BRIEF.md
# Linear CCD Line-Timing Generator

This block drives a linear CCD that has its own clock driver on chip. It produces two signals. The first is a transfer pulse, which moves the exposed charge into the shift register and so starts a line. The second is a pixel shift clock, which then clocks out one line of 2087 periods. Both are derived from the system clock. The shift clock has a programmable half-period divider, and the spacing around the transfer pulse is set by cycle counts. The block numbers every shift period and tags it with its line segment. During effective periods it also puts out a pixel index.

A sample strobe marks the last system cycle of every shift period, so a downstream ADC can capture the pixel once the sensor output has settled. The timing stream cannot be stalled, because the sensor has no way to pause. For that reason the output side has no ready input: the strobe together with the valid flag acts as the valid of a stream, and the consumer must accept every beat.

The settings are checked each time a line is about to begin. A setting that breaks the minimum timing is refused: no line starts and an error flag is raised. While enable stays high, lines repeat, separated by a programmable integration gap.

Top module: `ccd_line_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the transfer pulse, the shift clock, the strobe, valid, line_start, line_done and cfg_err are all low, the segment tag is 0 and the pixel index is 0.
- R2: A line starts only if the setup, transfer and hold counts are each at least 50 cycles (500 ns at the 10 ns default) and the half-period count is at least 10 (shift clock no faster than 5 MHz). If enable is high and the settings fail this check, the transfer pulse stays low and cfg_err is 1. When a line starts, cfg_err returns to 0.
- R3: The transfer pulse is high for exactly xfer_cyc cycles. Before it rises, the shift clock has been low for at least setup_cyc cycles. The first rise of the shift clock comes exactly hold_cyc cycles after the transfer pulse falls.
- R4: The shift clock is never high while the transfer pulse is high.
- R5: Each line has 2087 shift periods. Each period is high for exactly half_div cycles and then low for half_div cycles, which gives a 50 % duty cycle.
- R6: The strobe is a one-cycle pulse, once per period, placed 2*half_div-1 cycles after the rise of the shift clock.
- R7: The segment tag uses this encoding: 0 = dummy, 1 = optical black, 2 = effective, 3 = trailing dummy. By period number counted from 0, periods 0-12 are tagged 0, periods 13-30 are tagged 1, periods 31-32 are tagged 0, periods 33-2080 are tagged 2 and periods 2081-2086 are tagged 3.
- R8: The pixel index equals the period number minus 33 during effective periods and is 0 in every other period. The valid output is high only together with the strobe of an effective period.
- R9: line_start is high for one cycle, coinciding with the first shift-clock high of period 0. line_done is high for one cycle, in the cycle after the strobe of period 2086.
- R10: If enable is still high when a line ends, the next transfer pulse rises exactly gap_cyc+setup_cyc+2 cycles after line_done. If enable is low at the end of a line, no further transfer pulse is produced and the shift clock stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run lines while high |
| half_div | input | 8 | Shift-clock half period, in cycles |
| setup_cyc | input | 16 | Idle cycles of the shift clock before the transfer pulse |
| xfer_cyc | input | 16 | Transfer pulse width, in cycles |
| hold_cyc | input | 16 | Cycles from the fall of the transfer pulse to the first shift edge |
| gap_cyc | input | 16 | Integration gap between lines |
| xfer_o | output | 1 | Transfer (readout-gate) pulse |
| shclk_o | output | 1 | Pixel shift clock |
| strobe_o | output | 1 | Sample strobe, last cycle of each period |
| pix_valid_o | output | 1 | Strobe of an effective pixel |
| seg_o | output | 2 | Segment tag of the current period |
| pix_idx_o | output | 11 | Effective pixel index |
| line_start_o | output | 1 | First cycle of period 0 |
| line_done_o | output | 1 | Cycle after the last period |
| cfg_err_o | output | 1 | Settings were refused |

## Verification
The bench builds the block with its default parameters: a 10 ns clock, 500 ns minimum spacing, a 200 ns minimum shift period and the full 2087-period layout. Every segment boundary of a real line, including the optical-black window and the six trailing periods, is therefore checked on each strobe. The half-period stays at 10 or 11 so that three full lines fit in the run. These three lines cover back-to-back lines with a random gap, a stop caused by dropping enable, and settings that sit exactly at the acceptance limit. They are preceded by refusals of settings that fall one cycle short of a limit.

// File: rtl/ccd_lt_pkg.sv
package ccd_lt_pkg;
  typedef enum logic [1:0] {
    SEG_DUMMY  = 2'd0,
    SEG_BLACK  = 2'd1,
    SEG_ACTIVE = 2'd2,
    SEG_TAIL   = 2'd3
  } seg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_HOLD,
    ST_SHIFT,
    ST_GAP
  } lt_state_t;
endpackage

// File: rtl/ccd_lt_cfg_check.sv
module ccd_lt_cfg_check #(
  parameter int TW       = 16,
  parameter int DW       = 8,
  parameter int MIN_CYC  = 50,
  parameter int MIN_HALF = 10
) (
  input  logic [TW-1:0] setup_cyc,
  input  logic [TW-1:0] xfer_cyc,
  input  logic [TW-1:0] hold_cyc,
  input  logic [DW-1:0] half_div,
  output logic          ok
);
  localparam logic [TW-1:0] LIM_T = TW'(MIN_CYC);
  localparam logic [DW-1:0] LIM_H = DW'(MIN_HALF);

  always_comb begin
    ok = (setup_cyc >= LIM_T) && (xfer_cyc >= LIM_T) &&
         (hold_cyc >= LIM_T) && (half_div >= LIM_H);
  end
endmodule

// File: rtl/ccd_lt_pixdiv.sv
module ccd_lt_pixdiv #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] half_div,
  output logic          sclk,
  output logic          per_first,
  output logic          per_end
);
  localparam int PHW = DW + 1;

  logic [PHW-1:0] ph;
  logic [PHW-1:0] last_ph;
  logic [PHW-1:0] half_w;

  always_comb begin
    half_w    = {1'b0, half_div};
    last_ph   = {half_div, 1'b0} - PHW'(1);
    sclk      = run && (ph < half_w);
    per_first = run && (ph == '0);
    per_end   = run && (ph == last_ph);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ph <= '0;
    else if (!run)    ph <= '0;
    else if (per_end) ph <= '0;
    else              ph <= ph + PHW'(1);
  end

  // high phase lasts exactly half_div cycles
  p_high_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(sclk) && !sclk) |-> ($past(ph) == half_w - PHW'(1)));
endmodule

// File: rtl/ccd_lt_segmap.sv
module ccd_lt_segmap
  import ccd_lt_pkg::*;
#(
  parameter int LEAD_N = 33,
  parameter int BLK_AT = 13,
  parameter int BLK_N  = 18,
  parameter int ACT_N  = 2048,
  parameter int TAIL_N = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     step,
  output logic [$clog2(LEAD_N+ACT_N+TAIL_N)-1:0] per_num,
  output logic                     per_last,
  output seg_t                     seg,
  output logic [$clog2(ACT_N)-1:0] idx
);
  localparam int TOTAL = LEAD_N + ACT_N + TAIL_N;
  localparam int PW    = $clog2(TOTAL);
  localparam int IW    = $clog2(ACT_N);
  localparam logic [PW-1:0] P_BLK0 = PW'(BLK_AT);
  localparam logic [PW-1:0] P_BLK1 = PW'(BLK_AT + BLK_N);
  localparam logic [PW-1:0] P_ACT0 = PW'(LEAD_N);
  localparam logic [PW-1:0] P_TAIL = PW'(LEAD_N + ACT_N);
  localparam logic [PW-1:0] P_LAST = PW'(TOTAL - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    per_num <= '0;
    else if (!run) per_num <= '0;
    else if (step) per_num <= per_last ? '0 : per_num + PW'(1);
  end

  always_comb begin
    per_last = (per_num == P_LAST);
    idx      = '0;
    if (!run)                                       seg = SEG_DUMMY;
    else if (per_num >= P_TAIL)                     seg = SEG_TAIL;
    else if (per_num >= P_ACT0)                     seg = SEG_ACTIVE;
    else if (per_num >= P_BLK0 && per_num < P_BLK1) seg = SEG_BLACK;
    else                                            seg = SEG_DUMMY;
    if (seg == SEG_ACTIVE) idx = IW'(per_num - P_ACT0);
  end

  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    per_num <= P_LAST);
  p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && seg == SEG_ACTIVE && per_num != P_TAIL - PW'(1))
      |=> (idx == $past(idx) + IW'(1)));
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_lt_pkg::*;
#(
  parameter int CLK_NS       = 10,
  parameter int MIN_SPACE_NS = 500,
  parameter int MIN_PER_NS   = 200,
  parameter int TW           = 16,
  parameter int DW           = 8,
  parameter int GW           = 16,
  parameter int LEAD_N       = 33,
  parameter int BLK_AT       = 13,
  parameter int BLK_N        = 18,
  parameter int ACT_N        = 2048,
  parameter int TAIL_N       = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [DW-1:0]            half_div,
  input  logic [TW-1:0]            setup_cyc,
  input  logic [TW-1:0]            xfer_cyc,
  input  logic [TW-1:0]            hold_cyc,
  input  logic [GW-1:0]            gap_cyc,
  output logic                     xfer_o,
  output logic                     shclk_o,
  output logic                     strobe_o,
  output logic                     pix_valid_o,
  output logic [1:0]               seg_o,
  output logic [$clog2(ACT_N)-1:0] pix_idx_o,
  output logic                     line_start_o,
  output logic                     line_done_o,
  output logic                     cfg_err_o
);
  localparam int MIN_CYC  = (MIN_SPACE_NS + CLK_NS - 1) / CLK_NS;
  localparam int MIN_HALF = (MIN_PER_NS + 2*CLK_NS - 1) / (2*CLK_NS);
  localparam int CW       = (TW > GW) ? TW : GW;
  localparam int PW       = $clog2(LEAD_N + ACT_N + TAIL_N);
  localparam int IW       = $clog2(ACT_N);

  lt_state_t     state;
  logic [CW-1:0] cnt;
  logic [TW-1:0] l_setup, l_xfer, l_hold;
  logic [DW-1:0] l_half;
  logic [GW-1:0] l_gap;
  logic          cfg_ok, run, per_first, per_end, per_last, done_q, err_q;
  logic [PW-1:0] per_num;
  logic [IW-1:0] idx;
  seg_t          seg;

  ccd_lt_cfg_check #(.TW(TW), .DW(DW), .MIN_CYC(MIN_CYC), .MIN_HALF(MIN_HALF)) u_chk (
    .setup_cyc(setup_cyc), .xfer_cyc(xfer_cyc), .hold_cyc(hold_cyc),
    .half_div(half_div), .ok(cfg_ok));

  ccd_lt_pixdiv #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .half_div(l_half),
    .sclk(shclk_o), .per_first(per_first), .per_end(per_end));

  ccd_lt_segmap #(.LEAD_N(LEAD_N), .BLK_AT(BLK_AT), .BLK_N(BLK_N),
                  .ACT_N(ACT_N), .TAIL_N(TAIL_N)) u_seg (
    .clk(clk), .rst_n(rst_n), .run(run), .step(per_end),
    .per_num(per_num), .per_last(per_last), .seg(seg), .idx(idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      l_setup <= '0;
      l_xfer  <= '0;
      l_hold  <= '0;
      l_half  <= '0;
      l_gap   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (en) begin
          if (cfg_ok) begin
            l_setup <= setup_cyc;
            l_xfer  <= xfer_cyc;
            l_hold  <= hold_cyc;
            l_half  <= half_div;
            l_gap   <= gap_cyc;
            cnt     <= CW'(setup_cyc) - CW'(1);
            err_q   <= 1'b0;
            state   <= ST_SETUP;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_SETUP: if (cnt == '0) begin
          cnt   <= CW'(l_xfer) - CW'(1);
          state <= ST_XFER;
        end else cnt <= cnt - CW'(1);
        ST_XFER: if (cnt == '0) begin
          cnt   <= CW'(l_hold) - CW'(1);
          state <= ST_HOLD;
        end else cnt <= cnt - CW'(1);
        ST_HOLD: if (cnt == '0) state <= ST_SHIFT;
                 else cnt <= cnt - CW'(1);
        ST_SHIFT: if (per_end && per_last) begin
          cnt    <= CW'(l_gap);
          done_q <= 1'b1;
          state  <= ST_GAP;
        end
        ST_GAP: if (cnt == '0) state <= ST_IDLE;
                else cnt <= cnt - CW'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    run          = (state == ST_SHIFT);
    xfer_o       = (state == ST_XFER);
    strobe_o     = per_end;
    pix_valid_o  = per_end && (seg == SEG_ACTIVE);
    seg_o        = seg;
    pix_idx_o    = idx;
    line_start_o = per_first && (per_num == '0);
    line_done_o  = done_q;
    cfg_err_o    = err_q;
  end

  p_clk_idle_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |-> !shclk_o);
  p_setup_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_o) |-> !$past(shclk_o));
  p_cfg_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_o) |-> (l_xfer >= TW'(MIN_CYC) && l_setup >= TW'(MIN_CYC) &&
                       l_hold >= TW'(MIN_CYC) && l_half >= DW'(MIN_HALF)));
  p_done_after_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done_o |-> ($past(strobe_o) && $past(seg_o) == 2'd3));
  p_start_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_o |-> (shclk_o && seg_o == 2'd0));
  p_valid_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |-> (strobe_o && seg_o == 2'd2));
endmodule

// File: tb/test_ccd_line_timer.sv
module test_ccd_line_timer;
  localparam int TOTAL = 2087;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [7:0]  half_div = 8'd10;
  logic [15:0] setup_cyc = 16'd60, xfer_cyc = 16'd60, hold_cyc = 16'd60, gap_cyc = 16'd20;
  logic        xfer_o, shclk_o, strobe_o, pix_valid_o, line_start_o, line_done_o, cfg_err_o;
  logic [1:0]  seg_o;
  logic [10:0] pix_idx_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ccd_line_timer i_ccd_line_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .half_div(half_div),
    .setup_cyc(setup_cyc), .xfer_cyc(xfer_cyc), .hold_cyc(hold_cyc), .gap_cyc(gap_cyc),
    .xfer_o(xfer_o), .shclk_o(shclk_o), .strobe_o(strobe_o), .pix_valid_o(pix_valid_o),
    .seg_o(seg_o), .pix_idx_o(pix_idx_o), .line_start_o(line_start_o),
    .line_done_o(line_done_o), .cfg_err_o(cfg_err_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_seg(input int p);
    if (p < 13)        return 0;
    else if (p < 31)   return 1;
    else if (p < 33)   return 0;
    else if (p < 2081) return 2;
    else               return 3;
  endfunction

  function automatic int exp_idx(input int p);
    return (p >= 33 && p < 2081) ? p - 33 : 0;
  endfunction

  // monitor state
  longint cyc = 0, t_xrise = 0, t_xfall = 0, t_srise = 0, t_sfall = 0, t_done = 0;
  bit prev_x = 0, prev_s = 0, in_hold = 0, done_seen = 0, done_due = 0;
  int p_exp = 0, n_rise = 0, n_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!en) done_seen = 0;
      // R4
      if (xfer_o && shclk_o) chk(0, "R4", 1, 0);
      if (xfer_o && !prev_x) begin
        n_rise++;
        chk(cyc - t_sfall >= setup_cyc, "R3 setup", int'(cyc - t_sfall), int'(setup_cyc));
        if (done_seen)
          chk(cyc - t_done == gap_cyc + setup_cyc + 2, "R10 gap",
              int'(cyc - t_done), int'(gap_cyc + setup_cyc + 2));
        done_seen = 0;
        t_xrise = cyc;
        p_exp = 0;
      end
      if (!xfer_o && prev_x) begin
        chk(cyc - t_xrise == xfer_cyc, "R3 width", int'(cyc - t_xrise), int'(xfer_cyc));
        t_xfall = cyc;
        in_hold = 1;
      end
      if (shclk_o && !prev_s) begin
        if (in_hold)
          chk(cyc - t_xfall == hold_cyc, "R3 hold", int'(cyc - t_xfall), int'(hold_cyc));
        in_hold = 0;
        chk(line_start_o == (p_exp == 0), "R9 start", line_start_o, p_exp == 0);
        t_srise = cyc;
      end else if (line_start_o) chk(0, "R9 start stray", 1, 0);
      if (!shclk_o && prev_s) begin
        chk(cyc - t_srise == half_div, "R5 high", int'(cyc - t_srise), half_div);
        t_sfall = cyc;
      end
      if (line_done_o) begin
        chk(done_due, "R9 done", 1, done_due);
        chk(p_exp == TOTAL, "R5 periods", p_exp, TOTAL);
        n_done++;
        done_seen = 1;
        t_done = cyc;
      end else if (done_due) chk(0, "R9 done", 0, 1);
      done_due = 0;
      if (strobe_o) begin
        chk(cyc - t_srise == 2*half_div - 1, "R6 place", int'(cyc - t_srise), 2*half_div - 1);
        chk(seg_o == exp_seg(p_exp), "R7 seg", seg_o, exp_seg(p_exp));
        chk(pix_idx_o == exp_idx(p_exp), "R8 idx", pix_idx_o, exp_idx(p_exp));
        chk(pix_valid_o == (exp_seg(p_exp) == 2), "R8 valid", pix_valid_o, exp_seg(p_exp) == 2);
        p_exp++;
        if (p_exp == TOTAL) done_due = 1;
      end else if (pix_valid_o) chk(0, "R8 valid w/o strobe", 1, 0);
      prev_x = xfer_o;
      prev_s = shclk_o;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1288));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!xfer_o && !shclk_o && !strobe_o && !pix_valid_o, "R1 drives", xfer_o + shclk_o, 0);
    chk(seg_o == 0 && pix_idx_o == 0, "R1 tag", seg_o + pix_idx_o, 0);
    chk(!line_start_o && !line_done_o && !cfg_err_o, "R1 flags", cfg_err_o, 0);

    // R2 refused: width one short of the limit
    xfer_cyc = 16'd49;
    en = 1'b1;
    repeat (200) @(negedge clk);
    chk(n_rise == 0, "R2 short width", n_rise, 0);
    chk(cfg_err_o == 1, "R2 err", cfg_err_o, 1);
    // R2 refused: shift clock too fast
    xfer_cyc = 16'd60;
    half_div = 8'd9;
    repeat (100) @(negedge clk);
    chk(n_rise == 0, "R2 fast clock", n_rise, 0);
    chk(cfg_err_o == 1, "R2 err fast", cfg_err_o, 1);
    chk(shclk_o == 0, "R2 clock idle", shclk_o, 0);

    // random valid settings, two back-to-back lines
    en = 1'b0;
    @(negedge clk);
    half_div  = 8'(10 + $urandom % 2);
    setup_cyc = 16'(50 + $urandom % 31);
    xfer_cyc  = 16'(50 + $urandom % 31);
    hold_cyc  = 16'(50 + $urandom % 31);
    gap_cyc   = 16'($urandom % 201);
    en = 1'b1;
    wait (n_rise == 1);
    @(negedge clk);
    chk(cfg_err_o == 0, "R2 cleared", cfg_err_o, 0);
    wait (n_rise == 2);
    @(negedge clk);
    en = 1'b0;
    wait (n_done == 2);
    repeat (600) @(negedge clk);
    chk(n_rise == 2, "R10 stop", n_rise, 2);
    chk(shclk_o == 0, "R10 idle clock", shclk_o, 0);

    // corner: settings exactly at the limits, zero gap
    half_div = 8'd10;
    setup_cyc = 16'd50;
    xfer_cyc = 16'd50;
    hold_cyc = 16'd50;
    gap_cyc = 16'd0;
    en = 1'b1;
    wait (n_rise == 3);
    @(negedge clk);
    chk(cfg_err_o == 0, "R2 limits accepted", cfg_err_o, 0);
    en = 1'b0;
    wait (n_done == 3);
    repeat (100) @(negedge clk);
    chk(n_rise == 3, "R10 single line", n_rise, 3);
    finish_run();
  end
endmodule